// File: doc/BRIEF.md
# Overcurrent and Underload Fault Timers

This block is the timing and latching part of the protection logic for a bank of twelve output switches. Each switch has its own overcurrent timer. The timer starts when the switch is commanded on and its overcurrent comparator reports a current above the detection level. If that condition lasts for the selected delay, the switch is latched off and a shared overload status bit is set. A control bit selects a long or a short delay. The selection is captured when a timing event starts, so a later change to the bit does not affect an event that is already running.

Underload uses one timer for all channels. The first channel that enters underload starts it. A channel that enters underload while the timer is running only waits for the time that is left. When the timer expires, an underload status bit is set. The channels that are still in underload are latched off only if the underload-shutdown control bit is set.

A one-cycle clear strobe models the commit of a frame that carries the status-reset request. It clears all latch-offs, both status bits and all timers. If a fault is still present after the clear, it is timed again from the start. All delays are counted in pulses of a `tick` input, and the counts are parameters.

Top module: `fault_timer_top`

## Requirements
- R1: After reset, `oc_off`, `ul_off`, `ovld_stat` and `undld_stat` are all zero.
- R2: With `oc_fast`=0 when the event starts, a channel that has `cmd_en`=1 and `oc_flag`=1 is latched in `oc_off` on its OC_LONG_TICKS-th tick pulse, and not before. Clock cycles without a tick pulse do not advance the timer.
- R3: With `oc_fast`=1 when the event starts, the latch happens on the OC_SHORT_TICKS-th tick pulse.
- R4: A change of `oc_fast` after an overcurrent event has started does not change the delay of that event.
- R5: If `oc_flag` or `cmd_en` of a channel drops before expiry, that channel's timer is discarded. A later event then takes the full delay again.
- R6: An overcurrent latch-off sets `ovld_stat`, and only the bit of the offending channel is set in `oc_off`.
- R7: The underload timer is shared by all channels. A channel that enters underload while the timer runs is latched off at the same expiry as the first channel, when `ul_shut_en`=1. The expiry comes UL_TICKS tick pulses after the first channel entered underload.
- R8: Underload expiry sets `undld_stat`. With `ul_shut_en`=0, `ul_off` stays zero.
- R9: After the shared timer has expired, and while any channel is still in underload, a channel in underload is latched off as soon as `ul_shut_en`=1. No further tick pulse is needed.
- R10: A `clr_commit` pulse clears `oc_off`, `ul_off`, both status bits and all timers at the next clock edge. A fault that persists is then timed again with the full delay.
- R11: If no channel is in underload before expiry, the shared timer resets, and the next underload waits the full UL_TICKS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Timebase pulse; each high cycle counts one delay unit |
| cmd_en | input | NCH | Commanded on state of each switch |
| oc_flag | input | NCH | Overcurrent comparator output per switch |
| ul_flag | input | NCH | Underload comparator output per switch |
| oc_fast | input | 1 | Delay select: 1 = short overcurrent delay, 0 = long |
| ul_shut_en | input | 1 | 1 = latch off switches on underload expiry |
| clr_commit | input | 1 | One-cycle strobe: a committed frame requests status reset |
| oc_off | output | NCH | Overcurrent latched-off mask |
| ul_off | output | NCH | Underload latched-off mask |
| ovld_stat | output | 1 | Latched overload status |
| undld_stat | output | 1 | Latched underload status |

## Verification
The overcurrent path is tried with an uninterrupted fault under each delay setting, with the delay bit flipped in the middle of an event in both directions, and with the fault or the command dropped for one cycle. Together these show whether the delay is captured at the start and whether an interrupted event is discarded. The underload path is tried with a second channel that joins while the timer runs, which separates a shared timer from per-channel timers. It is also tried with shutdown disabled and then enabled after expiry, and with the condition removed just before expiry, which shows that the shared timer resets. Clearing while a fault persists shows that the fault is timed again from the start.

// File: rtl/fault_timer_pkg.sv
package fault_timer_pkg;

    typedef enum logic [1:0] {
        UL_IDLE = 2'd0,
        UL_RUN  = 2'd1,
        UL_DONE = 2'd2
    } ul_state_e;

    function automatic int unsigned cnt_bits(int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/oc_chan_timer.sv
module oc_chan_timer #(
    parameter int unsigned LONG_TICKS  = 200,
    parameter int unsigned SHORT_TICKS = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic armed,
    input  logic fast,
    input  logic clr,
    output logic latch_off
);
    import fault_timer_pkg::*;

    localparam int unsigned MAXD = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CW   = cnt_bits(MAXD);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
        logic          off;
    } oc_state_t;

    oc_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
            st_d.off = 1'b0;
        end else if (!armed || st_q.off) begin
            st_d.run = 1'b0;
            st_d.cnt = '0;
        end else if (!st_q.run) begin
            st_d.run = 1'b1;
            st_d.cnt = fast ? CW'(SHORT_TICKS) : CW'(LONG_TICKS);
        end else if (tick) begin
            if (st_q.cnt <= CW'(1)) begin
                st_d.off = 1'b1;
                st_d.run = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt - CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign latch_off = st_q.off;

    p_latch_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.off && !clr |=> st_q.off);

    p_latch_needs_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.off) |-> $past(armed && tick));

    p_count_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(MAXD));

    p_clear_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !st_q.off && !st_q.run);

endmodule

// File: rtl/ul_global_timer.sv
module ul_global_timer #(
    parameter int unsigned NCH      = 12,
    parameter int unsigned UL_TICKS = 350
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] want,
    input  logic           shut_en,
    input  logic           clr,
    output logic [NCH-1:0] off_mask,
    output logic           expired
);
    import fault_timer_pkg::*;

    localparam int unsigned CW = cnt_bits(UL_TICKS);

    typedef struct packed {
        ul_state_e      state;
        logic [CW-1:0]  cnt;
        logic [NCH-1:0] off;
    } ul_regs_t;

    ul_regs_t rg_d, rg_q;
    logic [NCH-1:0] cond;
    logic           any_ul;

    assign cond   = want & ~rg_q.off;
    assign any_ul = |cond;

    always_comb begin
        rg_d = rg_q;
        if (clr) begin
            rg_d.state = UL_IDLE;
            rg_d.cnt   = '0;
            rg_d.off   = '0;
        end else if (!any_ul) begin
            rg_d.state = UL_IDLE;
            rg_d.cnt   = '0;
        end else begin
            unique case (rg_q.state)
                UL_IDLE: begin
                    rg_d.state = UL_RUN;
                    rg_d.cnt   = CW'(UL_TICKS);
                end
                UL_RUN: begin
                    if (tick) begin
                        if (rg_q.cnt <= CW'(1)) begin
                            rg_d.state = UL_DONE;
                            rg_d.cnt   = '0;
                        end else begin
                            rg_d.cnt = rg_q.cnt - CW'(1);
                        end
                    end
                end
                UL_DONE: begin
                    if (shut_en) begin
                        rg_d.off = rg_q.off | cond;
                    end
                end
                default: begin
                    rg_d.state = UL_IDLE;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '{state: UL_IDLE, cnt: '0, off: '0};
        end else begin
            rg_q <= rg_d;
        end
    end

    assign off_mask = rg_q.off;
    assign expired  = (rg_q.state == UL_DONE) && any_ul;

    p_off_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((rg_q.off & ~$past(rg_q.off)) != '0) |-> $past(shut_en));

    p_idle_when_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !any_ul |=> rg_q.state == UL_IDLE);

    p_count_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rg_q.state == UL_RUN |-> (rg_q.cnt != '0) && (rg_q.cnt <= CW'(UL_TICKS)));

    p_clear_all_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> rg_q.off == '0);

endmodule

// File: rtl/fault_timer_top.sv
module fault_timer_top #(
    parameter int unsigned NCH            = 12,
    parameter int unsigned OC_LONG_TICKS  = 200,
    parameter int unsigned OC_SHORT_TICKS = 25,
    parameter int unsigned UL_TICKS       = 350
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [NCH-1:0] cmd_en,
    input  logic [NCH-1:0] oc_flag,
    input  logic [NCH-1:0] ul_flag,
    input  logic           oc_fast,
    input  logic           ul_shut_en,
    input  logic           clr_commit,
    output logic [NCH-1:0] oc_off,
    output logic [NCH-1:0] ul_off,
    output logic           ovld_stat,
    output logic           undld_stat
);

    typedef struct packed {
        logic ovld;
        logic undld;
    } stat_t;

    stat_t          stat_d, stat_q;
    logic           ul_expired;
    logic [NCH-1:0] oc_armed;

    assign oc_armed = cmd_en & oc_flag;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_oc
        oc_chan_timer #(
            .LONG_TICKS (OC_LONG_TICKS),
            .SHORT_TICKS(OC_SHORT_TICKS)
        ) u_oc (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .armed    (oc_armed[ch]),
            .fast     (oc_fast),
            .clr      (clr_commit),
            .latch_off(oc_off[ch])
        );
    end

    ul_global_timer #(
        .NCH     (NCH),
        .UL_TICKS(UL_TICKS)
    ) u_ul (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .want    (cmd_en & ul_flag),
        .shut_en (ul_shut_en),
        .clr     (clr_commit),
        .off_mask(ul_off),
        .expired (ul_expired)
    );

    always_comb begin
        stat_d = stat_q;
        if (clr_commit) begin
            stat_d = '0;
        end else begin
            stat_d.ovld  = stat_q.ovld  | (|oc_off);
            stat_d.undld = stat_q.undld | ul_expired;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= stat_d;
        end
    end

    assign ovld_stat  = stat_q.ovld;
    assign undld_stat = stat_q.undld;

    p_ovld_follows_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (|oc_off) && !clr_commit |=> ovld_stat);

    p_undld_with_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (|ul_off) |-> undld_stat);

    p_status_cleared_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr_commit |=> !ovld_stat && !undld_stat);

endmodule

// File: tb/fault_timer_top_test.sv
`timescale 1ns/1ps
module fault_timer_top_test;

    localparam int NCH = 12;
    localparam int LT  = 8;
    localparam int ST  = 3;
    localparam int UT  = 6;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic [NCH-1:0] cmd_en = '1;
    logic [NCH-1:0] oc_flag = '0;
    logic [NCH-1:0] ul_flag = '0;
    logic           oc_fast = 1'b0;
    logic           ul_shut_en = 1'b0;
    logic           clr_commit = 1'b0;
    logic [NCH-1:0] oc_off;
    logic [NCH-1:0] ul_off;
    logic           ovld_stat;
    logic           undld_stat;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    fault_timer_top #(
        .NCH(NCH), .OC_LONG_TICKS(LT), .OC_SHORT_TICKS(ST), .UL_TICKS(UT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_en(cmd_en),
        .oc_flag(oc_flag), .ul_flag(ul_flag), .oc_fast(oc_fast),
        .ul_shut_en(ul_shut_en), .clr_commit(clr_commit),
        .oc_off(oc_off), .ul_off(ul_off),
        .ovld_stat(ovld_stat), .undld_stat(undld_stat)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic clear_all();
        oc_flag = '0; ul_flag = '0; cmd_en = '1;
        @(negedge clk); clr_commit = 1'b1;
        @(negedge clk); clr_commit = 1'b0;
        idle(1);
    endtask

    task automatic t_reset();
        chk("R1 oc_off", 32'(oc_off), 0);
        chk("R1 ul_off", 32'(ul_off), 0);
        chk("R1 status", {30'd0, ovld_stat, undld_stat}, 0);
    endtask

    task automatic t_oc_long();
        clear_all(); oc_fast = 1'b0; oc_flag[3] = 1'b1;
        idle(20);
        chk("R2 no tick no latch", 32'(oc_off), 0);
        ticks(LT - 1); idle(2);
        chk("R2 before expiry", 32'(oc_off), 0);
        ticks(1); idle(2);
        chk("R6 only ch3 latched", 32'(oc_off), 32'h8);
        chk("R6 ovld_stat", 32'(ovld_stat), 1);
    endtask

    task automatic t_oc_short();
        clear_all(); oc_fast = 1'b1; oc_flag[7] = 1'b1;
        ticks(ST - 1); idle(2);
        chk("R3 before short expiry", 32'(oc_off), 0);
        ticks(1); idle(2);
        chk("R3 short latch", 32'(oc_off), 32'h80);
    endtask

    task automatic t_oc_freeze();
        clear_all(); oc_fast = 1'b0; oc_flag[0] = 1'b1;
        ticks(1); oc_fast = 1'b1;
        ticks(ST + 1); idle(2);
        chk("R4 long kept after switch", 32'(oc_off), 0);
        ticks(LT - ST - 2); idle(2);
        chk("R4 long latch", 32'(oc_off), 32'h1);
        clear_all(); oc_fast = 1'b1; oc_flag[11] = 1'b1;
        ticks(1); oc_fast = 1'b0;
        ticks(ST - 1); idle(2);
        chk("R4 short kept after switch", 32'(oc_off), 32'h800);
    endtask

    task automatic t_oc_restart();
        clear_all(); oc_fast = 1'b0; oc_flag[2] = 1'b1;
        ticks(LT - 3); oc_flag[2] = 1'b0; idle(1); oc_flag[2] = 1'b1;
        ticks(LT - 1); idle(2);
        chk("R5 flag drop restarts", 32'(oc_off), 0);
        ticks(1); idle(2);
        chk("R5 flag drop latch", 32'(oc_off), 32'h4);
        clear_all(); oc_flag[9] = 1'b1;
        ticks(LT - 3); cmd_en[9] = 1'b0; idle(1); cmd_en[9] = 1'b1;
        ticks(LT - 1); idle(2);
        chk("R5 cmd drop restarts", 32'(oc_off), 0);
        ticks(1); idle(2);
        chk("R5 cmd drop latch", 32'(oc_off), 32'h200);
    endtask

    task automatic t_clear_relatch();
        @(negedge clk); clr_commit = 1'b1;
        @(negedge clk); clr_commit = 1'b0;
        chk("R10 oc_off cleared", 32'(oc_off), 0);
        chk("R10 ovld cleared", 32'(ovld_stat), 0);
        ticks(LT - 1); idle(2);
        chk("R10 full delay again", 32'(oc_off), 0);
        ticks(1); idle(2);
        chk("R10 relatched", 32'(oc_off), 32'h200);
        chk("R10 ovld again", 32'(ovld_stat), 1);
    endtask

    task automatic t_ul_shared();
        clear_all(); ul_shut_en = 1'b1; ul_flag[0] = 1'b1;
        ticks(2); ul_flag[5] = 1'b1;
        ticks(UT - 3); idle(2);
        chk("R7 before shared expiry", 32'(ul_off), 0);
        chk("R7 no status yet", 32'(undld_stat), 0);
        ticks(1); idle(2);
        chk("R7 both latched at one expiry", 32'(ul_off), 32'h21);
        chk("R8 undld_stat", 32'(undld_stat), 1);
        chk("R7 overcurrent untouched", 32'(oc_off), 0);
    endtask

    task automatic t_ul_noshut();
        clear_all(); ul_shut_en = 1'b0; ul_flag[1] = 1'b1;
        ticks(UT); idle(2);
        chk("R8 status without shutdown", 32'(undld_stat), 1);
        chk("R8 mask stays clear", 32'(ul_off), 0);
        ul_flag[2] = 1'b1; idle(3);
        chk("R9 late joiner not latched while disabled", 32'(ul_off), 0);
        ul_shut_en = 1'b1; idle(2);
        chk("R9 latched at once on enable", 32'(ul_off), 32'h6);
        @(negedge clk); clr_commit = 1'b1;
        @(negedge clk); clr_commit = 1'b0;
        chk("R10 ul_off cleared", 32'(ul_off), 0);
        chk("R10 undld cleared", 32'(undld_stat), 0);
    endtask

    task automatic t_ul_reset();
        clear_all(); ul_shut_en = 1'b1; ul_flag[4] = 1'b1;
        ticks(UT - 2); ul_flag[4] = 1'b0; idle(1); ul_flag[4] = 1'b1;
        ticks(UT - 1); idle(2);
        chk("R11 timer restarted", 32'(ul_off), 0);
        ticks(1); idle(2);
        chk("R11 latch after full delay", 32'(ul_off), 32'h10);
    endtask

    initial begin
        idle(3); rst_n = 1'b1; idle(2);
        t_reset();
        t_oc_long();
        t_oc_short();
        t_oc_freeze();
        t_oc_restart();
        t_clear_relatch();
        t_ul_shared();
        t_ul_noshut();
        t_ul_reset();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule